// File: doc/BRIEF.md
# Masked Interrupt Cause Register

This block gathers interrupt requests from several device sources into one cause register, sixteen bits wide by default. It combines that register with a mask written by the host, and the combination drives a level interrupt line toward the host processor. The host reaches the block over a small register bus that carries byte and halfword accesses. There are three decoded addresses: a status address that holds the cause bits, a mask address, and a test address that forces the low eight causes.

Besides the level line, the block produces a one-cycle event pulse that tells the host side to re-sample the interrupt line. The pulse has two sources. A source request can ask for a delay before the pulse, and a down-counter provides it. A halfword write that changes the mask also produces a pulse, provided the old or the new mask covers a pending cause. The host clears the cause bits by writing the status address with a byte write. That write overwrites the register; it does not clear selected bits.

Top module: `irq_cause_ctrl`

## Requirements
- R1: While reset is held and for two clock edges after it is released, the cause register, the mask register and the delay counter are zero, and `irq_o` and `evt_o` are low.
- R2: At the clock edge that samples `src_req`, the block ORs `src_cause` into the cause register. A request never clears a bit that is already set.
- R3: `irq_o` is high exactly when the bitwise AND of the cause register and the mask register is non-zero.
- R4: A byte write (`bus_size`=0) to `STAT_ADDR` replaces the cause register with the written byte, zero-extended. A request in the same cycle is ORed on top of that value.
- R5: A halfword write (`bus_size`=1) to `MASK_ADDR` loads the mask. A byte write to `MASK_ADDR` leaves the mask unchanged.
- R6: A halfword write to `MASK_ADDR` makes `evt_o` high in the next cycle when two conditions hold: the new value differs from the old mask, and (old mask OR new mask) AND cause is non-zero.
- R7: A byte write to `TEST_ADDR` sets the cause register to 0x00FF. A request in the same cycle is ORed on top.
- R8: A request whose delay is d makes `evt_o` high for one cycle, exactly max(d,1) clock edges after the edge that sampled the request. A delay of 0 behaves as 1.
- R9: If a request arrives while a delay is pending, the counter takes the smaller of two values: the remaining count after this edge's decrement, and max(d,1). An expiry on the same edge still fires.
- R10: When `bus_rd` is high, `bus_rdata` returns the cause register for a halfword read of `STAT_ADDR` and the mask for a halfword read of `MASK_ADDR`. It returns 0 in every other case. The read is combinational and has no side effect.
- R11: A halfword write to `STAT_ADDR` leaves the cause register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 1 | Source request strobe |
| src_cause | input | CAUSE_W | Cause bits of the request |
| src_delay | input | DLY_W | Delay before the event, 0 treated as 1 |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_size | input | 1 | 0 = byte access, 1 = halfword access |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | CAUSE_W | Write data |
| bus_rdata | output | CAUSE_W | Read data, combinational |
| irq_o | output | 1 | Level interrupt: cause AND mask is non-zero |
| evt_o | output | 1 | One-cycle re-evaluation event |

## Verification
On every cycle, the assertions check the following:
- a request never drops a set cause bit;
- an empty mask or an empty cause keeps the line low;
- a byte write to the mask leaves it unchanged;
- the test address forces the low byte;
- a counter at one produces an event;
- a qualifying mask change produces an event;
- a reload never lengthens a pending delay.

Only the bench scenarios can show the exact event timing for each delay value, and that a longer original delay is discarded after a reload. The same holds for the zero-extension of byte writes to the status address, the behaviour of mask changes that do not qualify, and the read data returned across random sequences that mix requests, writes and forces.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    SZ_BYTE = 1'b0,
    SZ_HALF = 1'b1
  } acc_sz_e;
endpackage

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int CAUSE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic [CAUSE_W-1:0] req_cause,
  input  logic               ld_byte,
  input  logic [7:0]         byte_val,
  input  logic               force_low,
  output logic [CAUSE_W-1:0] cause_q
);
  localparam logic [CAUSE_W-1:0] FORCE_VAL = CAUSE_W'(8'hFF);

  logic [CAUSE_W-1:0] base;
  logic [CAUSE_W-1:0] cause_d;
  logic               cause_en;

  always_comb begin
    base = cause_q;
    if (ld_byte)   base = CAUSE_W'(byte_val);
    if (force_low) base = FORCE_VAL;
    cause_d  = req ? (base | req_cause) : base;
    cause_en = req | ld_byte | force_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (cause_en) cause_q <= cause_d;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int CAUSE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CAUSE_W-1:0] wdata,
  input  logic [CAUSE_W-1:0] cause,
  output logic [CAUSE_W-1:0] mask_q,
  output logic               reeval
);
  logic changed;
  logic overlap;

  always_comb begin
    changed = (wdata != mask_q);
    overlap = |((mask_q | wdata) & cause);
    reeval  = wr_en & changed & overlap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= '0;
    else if (wr_en) mask_q <= wdata;
  end
endmodule

// File: rtl/irq_delay_timer.sv
module irq_delay_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [DLY_W-1:0] delay,
  output logic [DLY_W-1:0] cnt_q,
  output logic             expire
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic [DLY_W-1:0] dec;
  logic [DLY_W-1:0] ld_val;
  logic [DLY_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    expire = (cnt_q == ONE);
    dec    = (cnt_q != '0) ? (cnt_q - ONE) : '0;
    ld_val = (delay == '0) ? ONE : delay;
    if (req) cnt_d = ((dec != '0) && (dec < ld_val)) ? dec : ld_val;
    else     cnt_d = dec;
    cnt_en = req | (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl #(
  parameter int               CAUSE_W   = 16,
  parameter int               DLY_W     = 8,
  parameter int               ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h28,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h2A,
  parameter logic [ADDR_W-1:0] TEST_ADDR = 8'h20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               src_req,
  input  logic [CAUSE_W-1:0] src_cause,
  input  logic [DLY_W-1:0]   src_delay,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic               bus_size,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [CAUSE_W-1:0] bus_wdata,
  output logic [CAUSE_W-1:0] bus_rdata,
  output logic               irq_o,
  output logic               evt_o
);
  import irq_pkg::*;

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_sync_n;
  acc_sz_e                sz;
  logic                   stat_byte_wr;
  logic                   test_byte_wr;
  logic                   mask_half_wr;
  logic [CAUSE_W-1:0]     cause_q;
  logic [CAUSE_W-1:0]     mask_q;
  logic [DLY_W-1:0]       cnt_q;
  logic                   reeval;
  logic                   expire;
  logic                   evt_d;
  logic                   evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_sync[SYNC_STAGES-1];

  always_comb begin
    sz           = acc_sz_e'(bus_size);
    stat_byte_wr = bus_wr && (sz == SZ_BYTE) && (bus_addr == STAT_ADDR);
    test_byte_wr = bus_wr && (sz == SZ_BYTE) && (bus_addr == TEST_ADDR);
    mask_half_wr = bus_wr && (sz == SZ_HALF) && (bus_addr == MASK_ADDR);
  end

  irq_cause_reg #(.CAUSE_W(CAUSE_W)) u_cause (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req       (src_req),
    .req_cause (src_cause),
    .ld_byte   (stat_byte_wr),
    .byte_val  (bus_wdata[7:0]),
    .force_low (test_byte_wr),
    .cause_q   (cause_q)
  );

  irq_mask_reg #(.CAUSE_W(CAUSE_W)) u_mask (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (mask_half_wr),
    .wdata  (bus_wdata),
    .cause  (cause_q),
    .mask_q (mask_q),
    .reeval (reeval)
  );

  irq_delay_timer #(.DLY_W(DLY_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .req    (src_req),
    .delay  (src_delay),
    .cnt_q  (cnt_q),
    .expire (expire)
  );

  assign evt_d = expire | reeval;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) evt_q <= 1'b0;
    else             evt_q <= evt_d;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && (sz == SZ_HALF)) begin
      if (bus_addr == STAT_ADDR)      bus_rdata = cause_q;
      else if (bus_addr == MASK_ADDR) bus_rdata = mask_q;
    end
  end

  assign irq_o = |(cause_q & mask_q);
  assign evt_o = evt_q;
endmodule

// File: rtl/irq_cause_ctrl_chk.sv
module irq_cause_ctrl_chk #(
  parameter int                CAUSE_W   = 16,
  parameter int                DLY_W     = 8,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h2A,
  parameter logic [ADDR_W-1:0] TEST_ADDR = 8'h20
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               src_req,
  input logic [CAUSE_W-1:0] src_cause,
  input logic               stat_byte_wr,
  input logic               test_byte_wr,
  input logic               bus_wr,
  input logic               bus_size,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [CAUSE_W-1:0] bus_wdata,
  input logic [CAUSE_W-1:0] cause_q,
  input logic [CAUSE_W-1:0] mask_q,
  input logic [DLY_W-1:0]   cnt_q,
  input logic               irq_o,
  input logic               evt_o
);
  assert_req_keeps_bits_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (src_req && !stat_byte_wr && !test_byte_wr) |=>
      (((cause_q & $past(src_cause)) == $past(src_cause)) &&
       ((cause_q & $past(cause_q)) == $past(cause_q))));

  assert_no_mask_no_irq_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((mask_q == '0) || (cause_q == '0)) |-> !irq_o);

  assert_byte_mask_ignored_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && !bus_size && (bus_addr == MASK_ADDR)) |=> (mask_q == $past(mask_q)));

  assert_mask_reeval_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_size && (bus_addr == MASK_ADDR) && (bus_wdata != mask_q) &&
     (((mask_q | bus_wdata) & cause_q) != '0)) |=> evt_o);

  assert_test_force_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && !bus_size && (bus_addr == TEST_ADDR)) |=> (cause_q[7:0] == 8'hFF));

  assert_expiry_event_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cnt_q == DLY_W'(1)) |=> evt_o);

  assert_reload_shorter_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (src_req && (cnt_q > DLY_W'(1))) |=> (cnt_q <= $past(cnt_q) - DLY_W'(1)));
endmodule

bind irq_cause_ctrl irq_cause_ctrl_chk #(
  .CAUSE_W   (CAUSE_W),
  .DLY_W     (DLY_W),
  .ADDR_W    (ADDR_W),
  .MASK_ADDR (MASK_ADDR),
  .TEST_ADDR (TEST_ADDR)
) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .src_req      (src_req),
  .src_cause    (src_cause),
  .stat_byte_wr (stat_byte_wr),
  .test_byte_wr (test_byte_wr),
  .bus_wr       (bus_wr),
  .bus_size     (bus_size),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .cause_q      (cause_q),
  .mask_q       (mask_q),
  .cnt_q        (cnt_q),
  .irq_o        (irq_o),
  .evt_o        (evt_o)
);

// File: tb/irq_cause_ctrl_tb.sv
module irq_cause_ctrl_tb;
  localparam logic [7:0] A_STAT = 8'h28;
  localparam logic [7:0] A_MASK = 8'h2A;
  localparam logic [7:0] A_TEST = 8'h20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        src_req;
  logic [15:0] src_cause;
  logic [7:0]  src_delay;
  logic        bus_wr, bus_rd, bus_size;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq_o, evt_o;

  int n_tests = 0;
  int n_fail  = 0;

  logic [15:0] cause_m, mask_m;
  logic [7:0]  cnt_m;
  logic        evt_m;

  always #4 clk = ~clk;

  irq_cause_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_cause(src_cause),
    .src_delay(src_delay), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .evt_o(evt_o)
  );

  task automatic check(input logic ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] eff_delay(input logic [7:0] d);
    return (d == 8'd0) ? 8'd1 : d;
  endfunction

  task automatic idle_inputs();
    src_req = 0; src_cause = '0; src_delay = '0;
    bus_wr = 0; bus_rd = 0; bus_size = 0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic check_state(input string tag);
    bus_rd = 1; bus_size = 1; bus_addr = A_STAT; #1;
    check(bus_rdata == cause_m, {tag, " R10 cause read"}, bus_rdata, cause_m);
    bus_addr = A_MASK; #1;
    check(bus_rdata == mask_m, {tag, " R10 mask read"}, bus_rdata, mask_m);
    bus_size = 0; #1;
    check(bus_rdata == 16'h0, {tag, " R10 byte read zero"}, bus_rdata, 16'h0);
    bus_rd = 0; bus_addr = '0;
    check(irq_o == |(cause_m & mask_m), {tag, " R3 irq level"}, 16'(irq_o), 16'(|(cause_m & mask_m)));
    check(evt_o == evt_m, {tag, " R6/R8 event"}, 16'(evt_o), 16'(evt_m));
  endtask

  task automatic step(input logic req, input logic [15:0] c, input logic [7:0] d,
                      input logic wr, input logic hw, input logic [7:0] a,
                      input logic [15:0] wd, input string tag);
    logic        mevt;
    logic [7:0]  dec;
    logic [15:0] base;
    check_state(tag);
    src_req = req; src_cause = c; src_delay = d;
    bus_wr = wr; bus_size = hw; bus_addr = a; bus_wdata = wd;
    mevt = (cnt_m == 8'd1);
    dec  = (cnt_m != 0) ? cnt_m - 8'd1 : 8'd0;
    base = cause_m;
    if (wr && !hw && a == A_STAT) base = {8'h00, wd[7:0]};
    if (wr && !hw && a == A_TEST) base = 16'h00FF;
    if (req) base = base | c;
    if (wr && hw && a == A_MASK) begin
      if (wd != mask_m && ((mask_m | wd) & cause_m) != 0) mevt = 1'b1;
      mask_m = wd;
    end
    if (req) cnt_m = (dec != 0 && dec < eff_delay(d)) ? dec : eff_delay(d);
    else     cnt_m = dec;
    cause_m = base;
    evt_m   = mevt;
    @(posedge clk); @(negedge clk);
    idle_inputs();
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_inputs();
    cause_m = 0; mask_m = 0; cnt_m = 0; evt_m = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    check(irq_o == 0 && evt_o == 0, "R1 outputs in reset", 16'({irq_o, evt_o}), 16'h0);
    bus_rd = 1; bus_size = 1; bus_addr = A_STAT; #1;
    check(bus_rdata == 0, "R1 cause in reset", bus_rdata, 16'h0);
    bus_rd = 0;
    rst_n = 1;
    repeat (3) @(negedge clk);
    check_state("R1 after release");

    // R2: requests OR in without delay interplay
    step(1, 16'h0101, 8'd0, 0, 0, 0, 0, "R2 req a");
    step(1, 16'h8000, 8'd3, 0, 0, 0, 0, "R2 req b");
    idle(4, "R8 wait");
    // R5: halfword mask write, byte mask write ignored
    step(0, 0, 0, 1, 1, A_MASK, 16'h8001, "R5 mask hw");
    step(0, 0, 0, 1, 0, A_MASK, 16'h0000, "R5 mask byte");
    idle(2, "R3 irq high");
    // R6: same mask (no event), change without overlap (no event)
    step(0, 0, 0, 1, 1, A_MASK, 16'h8001, "R6 same mask");
    step(0, 0, 0, 1, 0, A_STAT, 16'hAB00, "R4 byte clear");
    step(0, 0, 0, 1, 1, A_MASK, 16'h0100, "R6 no overlap");
    idle(1, "R6 check");
    // R11: halfword status write ignored
    step(1, 16'h0100, 8'd1, 0, 0, 0, 0, "R2 req c");
    step(0, 0, 0, 1, 1, A_STAT, 16'h0000, "R11 hw stat");
    idle(2, "R11 check");
    // R4: byte write replaces, zero-extended, with same-cycle request
    step(1, 16'h4000, 8'd2, 1, 0, A_STAT, 16'hFF5A, "R4 byte+req");
    idle(3, "R4 check");
    // R7: test force
    step(0, 0, 0, 1, 0, A_TEST, 16'h0000, "R7 force");
    step(0, 0, 0, 1, 1, A_MASK, 16'h0000, "R6 mask drop overlap");
    idle(2, "R7 check");
    // R9: long delay then shorter reload; original long expiry must not fire
    step(1, 16'h0002, 8'd10, 0, 0, 0, 0, "R9 long");
    idle(2, "R9 run");
    step(1, 16'h0004, 8'd3, 0, 0, 0, 0, "R9 short");
    idle(12, "R9 expiry");
    // R9: reload with larger delay keeps remaining
    step(1, 16'h0008, 8'd4, 0, 0, 0, 0, "R9 first");
    step(1, 16'h0010, 8'd9, 0, 0, 0, 0, "R9 larger");
    idle(12, "R9 keep");
    // R8: delay values 0 and 255 boundary
    step(1, 16'h0020, 8'd0, 0, 0, 0, 0, "R8 zero delay");
    idle(3, "R8 zero check");
    step(1, 16'h0040, 8'd255, 0, 0, 0, 0, "R8 max delay");
    idle(258, "R8 max check");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [15:0] rc;
      op = int'($urandom_range(0, 9));
      rc = 16'(1) << $urandom_range(0, 15);
      case (op)
        0, 1: step(1, rc, 8'($urandom_range(0, 12)), 0, 0, 0, 0, "R2/R8 rand req");
        2: step(0, 0, 0, 1, 0, A_STAT, 16'($urandom), "R4 rand");
        3: step(0, 0, 0, 1, 0, A_TEST, 16'($urandom), "R7 rand");
        4: step(0, 0, 0, 1, 1, A_MASK, 16'($urandom) & 16'($urandom), "R6 rand");
        5: step(0, 0, 0, 1, 1, A_STAT, 16'($urandom), "R11 rand");
        6: step(0, 0, 0, 1, 0, A_MASK, 16'($urandom), "R5 rand");
        7: step(1, rc, 8'($urandom_range(0, 5)), 1, 0, A_STAT, 16'($urandom), "R4/R9 rand");
        default: step(0, 0, 0, 0, 0, 0, 0, "R3 rand idle");
      endcase
    end
    idle(16, "final drain");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule